// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects 34 interrupt lines, each with its own enable bit, pending flag and 3-bit priority, and presents the most urgent deliverable one to the processor as a vector number. Software reaches the per-line state through a small word-addressed register port: bitmap words that set or clear a bit wherever a 1 is written, byte-wide priority fields, a grouping value, a priority mask level and a global delivery gate. Hardware lines set pending flags directly. Software can also set or clear a pending flag.

Arbitration runs every cycle over the lines that are both enabled and pending. The lowest priority number wins, and a tie goes to the lower line number. The winner is delivered only if the gate is open, the mask does not block it and its preemption group is more urgent than the handler now running. The delivery request is registered. It is offered as a valid/accept pair: `irq_valid` and `irq_vector` stay up until the processor pulses `irq_ack` with that vector. No back-pressure reaches the lines, which simply stay pending. While the request waits, the vector may change or the request may drop if the register state changes. A handler return is signalled on `irq_exit`. An internal stack of active preemption levels restores the previous level on each return.

Top module: `nest_irq_ctrl`

Register word addresses: 0/1 enable set (lines 0-31 / 32-33), 2/3 enable clear, 4/5 pending set, 6/7 pending clear. Words 0-3 read back the enable bitmap and words 4-7 read back the pending bitmap. Word 8 holds the grouping value in bits 1:0. Word 9 holds the mask level in bits 7:5. Word 10 holds the gate in bit 0. Priority words start at word 16: line n sits in word 16+n/4, byte lane n%4, and uses bits 7:5 of that byte.

## Requirements
- R1: After reset no line is enabled or pending, every priority, the grouping and the mask read 0, the gate reads 1, and `irq_valid` is 0.
- R2: A write to an enable set word sets, and a write to an enable clear word clears, exactly the lines whose data bit is 1; bits written 0 leave their lines unchanged; words 0-3 read back the enable bitmap.
- R3: Each line's priority is the 8-bit byte at word 16+n/4, lane n%4; only bits 7:5 are stored and arbitrated, and the lower 5 bits read back as 0 (for example 0x9F reads back as 0x80).
- R4: A high level on `irq_in[n]`, or a 1 written to bit n of a pending set word, makes line n pending; a 1 written to a pending clear word discards the request; words 4-7 read back the pending bitmap.
- R5: A pending line whose enable bit is 0 stays pending and is not delivered; it is delivered once it is enabled.
- R6: Among enabled pending lines the smallest priority value wins, and a tie goes to the lower line number; `irq_valid`/`irq_vector` follow the register state one clock later.
- R7: With a nonzero mask level L (word 9, bits 7:5), lines of priority L or greater are not delivered; a mask of 0 blocks nothing.
- R8: Writing 0 to the gate (word 10, bit 0) stops all delivery without changing any enable bit; writing 1 resumes it.
- R9: On `irq_ack` the acknowledged line's pending flag clears, its preemption level becomes the running level, and `irq_valid` is 0 in the following cycle.
- R10: With grouping M (0 to 3), a line's preemption group is its priority with the low M bits cleared; while a handler runs, a request is delivered only when its group is strictly smaller; an equal-group request waits and is delivered after the handler returns.
- R11: On `irq_exit` the previous running level is restored; with no handler active every group may be delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | 34 | Interrupt lines, high sets pending |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| irq_valid | output | 1 | Interrupt request to the processor |
| irq_vector | output | 6 | Line number of the request |
| irq_ack | input | 1 | Processor accepts the request |
| ack_vector | input | 6 | Line number being accepted |
| irq_exit | input | 1 | Running handler returns |

## Verification
The assertions assume that the processor pulses `irq_ack` only while `irq_valid` is high and with `ack_vector` equal to `irq_vector`, that `irq_exit` comes only while a handler is active, and that acceptance and return never fall in the same cycle. The directed stimulus keeps to this. Each accept is issued right after the bench has seen the request with the matching vector. Every scenario returns from as many handlers as it accepted, and accept and return pulses are always driven in separate cycles.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NIC_LINES     = 34;
  localparam int NIC_PRIO_BITS = 3;
  localparam int NIC_DATA_W    = 32;
  localparam int NIC_ADDR_W    = 6;

  localparam int A_EN_SET   = 0;
  localparam int A_EN_CLR   = 2;
  localparam int A_PEND_SET = 4;
  localparam int A_PEND_CLR = 6;
  localparam int A_GROUP    = 8;
  localparam int A_MASK     = 9;
  localparam int A_GATE     = 10;
  localparam int A_PRIO     = 16;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
#(
  parameter int NUM_LINES = NIC_LINES,
  parameter int PRIO_BITS = NIC_PRIO_BITS,
  parameter int ADDR_W    = NIC_ADDR_W,
  parameter int DATA_W    = NIC_DATA_W,
  localparam int VEC_W    = $clog2(NUM_LINES),
  localparam int GRP_W    = $clog2(PRIO_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 ack_ok,
  input  logic [VEC_W-1:0]     ack_vector,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [PRIO_BITS-1:0] prio_q [NUM_LINES],
  output logic [GRP_W-1:0]     grp_q,
  output logic [PRIO_BITS-1:0] mask_q,
  output logic                 gate_q
);
  localparam int FIELD_LO = 8 - PRIO_BITS;

  logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr, ack_hit;
  logic [GRP_W-1:0]     grp_in;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int base, input int line);
    return a == ADDR_W'(base + line / 32);
  endfunction

  // per-line decode of the set/clear bitmap words
  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_dec
      assign en_set[i]  = wr_en && hit(wr_addr, A_EN_SET, i)   && wr_data[i % 32];
      assign en_clr[i]  = wr_en && hit(wr_addr, A_EN_CLR, i)   && wr_data[i % 32];
      assign pd_set[i]  = wr_en && hit(wr_addr, A_PEND_SET, i) && wr_data[i % 32];
      assign pd_clr[i]  = wr_en && hit(wr_addr, A_PEND_CLR, i) && wr_data[i % 32];
      assign ack_hit[i] = ack_ok && (ack_vector == VEC_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= (pend_q | irq_in | pd_set) & ~pd_clr & ~ack_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (wr_addr == ADDR_W'(A_PRIO + i / 4))
          prio_q[i] <= wr_data[(i % 4) * 8 + FIELD_LO +: PRIO_BITS];
    end
  end

  assign grp_in = wr_data[GRP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q  <= '0;
      mask_q <= '0;
      gate_q <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_GROUP))
        grp_q <= (int'(grp_in) > PRIO_BITS) ? GRP_W'(PRIO_BITS) : grp_in;
      if (wr_addr == ADDR_W'(A_MASK))
        mask_q <= wr_data[FIELD_LO +: PRIO_BITS];
      if (wr_addr == ADDR_W'(A_GATE))
        gate_q <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (hit(rd_addr, A_EN_SET, i) || hit(rd_addr, A_EN_CLR, i))
        rd_data[i % 32] = en_q[i];
      if (hit(rd_addr, A_PEND_SET, i) || hit(rd_addr, A_PEND_CLR, i))
        rd_data[i % 32] = pend_q[i];
      if (rd_addr == ADDR_W'(A_PRIO + i / 4))
        rd_data[(i % 4) * 8 + FIELD_LO +: PRIO_BITS] = prio_q[i];
    end
    if (rd_addr == ADDR_W'(A_GROUP)) rd_data[GRP_W-1:0] = grp_q;
    if (rd_addr == ADDR_W'(A_MASK))  rd_data[FIELD_LO +: PRIO_BITS] = mask_q;
    if (rd_addr == ADDR_W'(A_GATE))  rd_data[0] = gate_q;
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_LINES = NIC_LINES,
  parameter int PRIO_BITS = NIC_PRIO_BITS,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] cand,
  input  logic [PRIO_BITS-1:0] prio [NUM_LINES],
  output logic                 any,
  output logic [VEC_W-1:0]     win_idx,
  output logic [PRIO_BITS-1:0] win_prio
);
  // scan upward; a strict compare keeps the lower index on a tie
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!any || prio[i] < win_prio)) begin
        any      = 1'b1;
        win_idx  = VEC_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
#(
  parameter int PRIO_BITS = NIC_PRIO_BITS,
  localparam int DEPTH    = 1 << PRIO_BITS,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [PRIO_BITS-1:0] push_lvl,
  input  logic                 pop,
  output logic [PRIO_BITS:0]   top_lvl,
  output logic [CNT_W-1:0]     depth
);
  logic [PRIO_BITS-1:0] stk [DEPTH];
  logic [IDX_W-1:0]     top_idx;

  assign top_idx = IDX_W'(depth - CNT_W'(1));
  assign top_lvl = (depth == '0) ? (PRIO_BITS + 1)'(DEPTH) : {1'b0, stk[top_idx]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push && depth != CNT_W'(DEPTH)) begin
      stk[IDX_W'(depth)] <= push_lvl;
      depth <= depth + CNT_W'(1);
    end else if (pop && depth != '0) begin
      depth <= depth - CNT_W'(1);
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES = NIC_LINES,
  parameter int PRIO_BITS = NIC_PRIO_BITS,
  parameter int ADDR_W    = NIC_ADDR_W,
  parameter int DATA_W    = NIC_DATA_W,
  localparam int VEC_W    = $clog2(NUM_LINES),
  localparam int GRP_W    = $clog2(PRIO_BITS + 1),
  localparam int STK_DEPTH = 1 << PRIO_BITS,
  localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vector,
  input  logic                 irq_ack,
  input  logic [VEC_W-1:0]     ack_vector,
  input  logic                 irq_exit
);
  logic [NUM_LINES-1:0] en_q, pend_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_LINES];
  logic [GRP_W-1:0]     grp_q;
  logic [PRIO_BITS-1:0] mask_q;
  logic                 gate_q;
  logic                 ack_ok;
  logic                 any;
  logic [VEC_W-1:0]     win_idx;
  logic [PRIO_BITS-1:0] win_prio, ack_prio;
  logic [PRIO_BITS:0]   top_lvl;
  logic [CNT_W-1:0]     stk_depth;
  logic                 mask_ok, preempt_ok, fire;

  // preemption group: priority with the low M subpriority bits cleared
  function automatic logic [PRIO_BITS-1:0] grp_lvl(input logic [PRIO_BITS-1:0] p,
                                                   input logic [GRP_W-1:0] m);
    logic [PRIO_BITS-1:0] keep;
    keep = '1;
    for (int b = 0; b < PRIO_BITS; b++)
      if (b < int'(m)) keep[b] = 1'b0;
    return p & keep;
  endfunction

  assign ack_ok = irq_ack && (int'(ack_vector) < NUM_LINES);

  nic_regs #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ack_ok(ack_ok), .ack_vector(ack_vector),
    .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q),
    .grp_q(grp_q), .mask_q(mask_q), .gate_q(gate_q)
  );

  nic_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_arb (
    .cand(en_q & pend_q), .prio(prio_q),
    .any(any), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign ack_prio = prio_q[ack_vector];

  nic_level_stack #(.PRIO_BITS(PRIO_BITS)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(ack_ok), .push_lvl(grp_lvl(ack_prio, grp_q)),
    .pop(irq_exit && !ack_ok),
    .top_lvl(top_lvl), .depth(stk_depth)
  );

  assign mask_ok    = (mask_q == '0) || (win_prio < mask_q);
  assign preempt_ok = top_lvl[PRIO_BITS] ||
                      (grp_lvl(win_prio, grp_q) < grp_lvl(top_lvl[PRIO_BITS-1:0], grp_q));
  assign fire       = any && gate_q && mask_ok && preempt_ok && !irq_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= fire;
      irq_vector <= fire ? win_idx : '0;
    end
  end
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int NUM_LINES = 34,
  parameter int DEPTH     = 8,
  localparam int VEC_W    = $clog2(NUM_LINES),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_valid,
  input logic [VEC_W-1:0]     irq_vector,
  input logic                 irq_ack,
  input logic [VEC_W-1:0]     ack_vector,
  input logic                 irq_exit,
  input logic                 wr_en,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] pend_q,
  input logic                 gate_q,
  input logic [CNT_W-1:0]     depth
);
  logic [VEC_W-1:0] ack_vec_d;
  always_ff @(posedge clk) ack_vec_d <= ack_vector;

  // R2: enable bitmap only moves on a register write
  assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

  // R8: closed gate means no request next cycle
  assert_gate_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |=> !irq_valid);

  // R9: request withdrawn right after acceptance
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_valid);

  // R9: accepted line is no longer pending
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && int'(ack_vector) < NUM_LINES) |=> !pend_q[ack_vec_d]);

  // R6: delivered vector names an existing line
  assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> int'(irq_vector) < NUM_LINES);

  // R11: a return with no accept pops one level
  assert_exit_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_exit && !irq_ack && depth != '0) |=> depth == $past(depth) - CNT_W'(1));

  // R10: the stack never grows past one entry per level
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depth) <= DEPTH);
endmodule

bind nest_irq_ctrl nic_checker #(.NUM_LINES(NUM_LINES), .DEPTH(STK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .irq_ack(irq_ack), .ack_vector(ack_vector), .irq_exit(irq_exit), .wr_en(wr_en),
  .en_q(en_q), .pend_q(pend_q), .gate_q(gate_q), .depth(stk_depth)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [33:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [5:0]  irq_vector;
  logic        irq_ack = 1'b0;
  logic [5:0]  ack_vector = '0;
  logic        irq_exit = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .ack_vector(ack_vector), .irq_exit(irq_exit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic accept(input logic [5:0] v);
    @(negedge clk);
    irq_ack = 1'b1; ack_vector = v;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic leave();
    @(negedge clk);
    irq_exit = 1'b1;
    @(negedge clk);
    irq_exit = 1'b0;
  endtask

  // expect the request state one cycle after the last state change
  task automatic expect_req(input string req, input logic v, input logic [5:0] vec);
    tick();
    check({req, " valid"}, 32'(irq_valid), 32'(v));
    if (v) check({req, " vector"}, 32'(irq_vector), 32'(vec));
  endtask

  task automatic cleanup();
    wr(6'd2, 32'hFFFF_FFFF); wr(6'd3, 32'hFFFF_FFFF);
    wr(6'd6, 32'hFFFF_FFFF); wr(6'd7, 32'hFFFF_FFFF);
    for (int w = 16; w <= 24; w++) wr(6'(w), 32'h0);
    wr(6'd8, 32'h0); wr(6'd9, 32'h0); wr(6'd10, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 valid", 32'(irq_valid), 32'h0);
    rd(6'd0, d);  check("R1 enable", d, 32'h0);
    rd(6'd5, d);  check("R1 pending", d, 32'h0);
    rd(6'd16, d); check("R1 priority", d, 32'h0);
    rd(6'd9, d);  check("R1 mask", d, 32'h0);
    rd(6'd10, d); check("R1 gate", d, 32'h1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(6'd0, 32'h5); wr(6'd0, 32'h2);
    rd(6'd0, d); check("R2 set keeps others", d, 32'h7);
    wr(6'd2, 32'h1);
    rd(6'd2, d); check("R2 clear one", d, 32'h6);
    wr(6'd1, 32'h3);
    rd(6'd1, d); check("R2 high word", d, 32'h3);
    cleanup();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(6'd16, 32'h3F5F_7F9F);
    rd(6'd16, d); check("R3 upper bits only", d, 32'h2040_6080);
    wr(6'd24, 32'hFFFF_FFFF);
    rd(6'd24, d); check("R3 last word", d, 32'h0000_E0E0);
    cleanup();
  endtask

  task automatic t_pend();
    logic [31:0] d;
    wr(6'd4, 32'h8);
    rd(6'd4, d); check("R4 sw set", d, 32'h8);
    expect_req("R5 disabled", 1'b0, 6'd0);
    rd(6'd4, d); check("R5 still pending", d, 32'h8);
    wr(6'd0, 32'h8);
    expect_req("R5 enabled", 1'b1, 6'd3);
    wr(6'd6, 32'h8);
    expect_req("R4 discard", 1'b0, 6'd0);
    rd(6'd4, d); check("R4 cleared", d, 32'h0);
    wr(6'd1, 32'h2);
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk); irq_in[33] = 1'b0;
    rd(6'd5, d); check("R4 hw line", d, 32'h2);
    expect_req("R4 hw deliver", 1'b1, 6'd33);
    cleanup();
  endtask

  task automatic t_arb();
    wr(6'd17, 32'h0000_6000); wr(6'd18, 32'h0040_0000); wr(6'd19, 32'h0000_0040);
    wr(6'd0, 32'h1420); wr(6'd4, 32'h1420);
    expect_req("R6 lowest value", 1'b1, 6'd10);
    wr(6'd6, 32'h400);
    expect_req("R6 next", 1'b1, 6'd12);
    wr(6'd6, 32'h1000);
    expect_req("R6 last", 1'b1, 6'd5);
    cleanup();
    wr(6'd0, 32'h84); wr(6'd4, 32'h84);
    expect_req("R6 tie lower index", 1'b1, 6'd2);
    cleanup();
  endtask

  task automatic t_mask();
    wr(6'd17, 32'h80); wr(6'd9, 32'h80);
    wr(6'd0, 32'h10); wr(6'd4, 32'h10);
    expect_req("R7 blocked at level", 1'b0, 6'd0);
    wr(6'd9, 32'hA0);
    expect_req("R7 passes below", 1'b1, 6'd4);
    wr(6'd9, 32'h0);
    expect_req("R7 zero no mask", 1'b1, 6'd4);
    cleanup();
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(6'd0, 32'h40); wr(6'd10, 32'h0); wr(6'd4, 32'h40);
    expect_req("R8 gate closed", 1'b0, 6'd0);
    rd(6'd0, d); check("R8 enable kept", d, 32'h40);
    wr(6'd10, 32'h1);
    expect_req("R8 gate open", 1'b1, 6'd6);
    cleanup();
  endtask

  task automatic t_nest();
    logic [31:0] d;
    wr(6'd16, 32'h6020_6000); wr(6'd0, 32'hE);
    wr(6'd4, 32'h2);
    expect_req("R9 first", 1'b1, 6'd1);
    accept(6'd1);
    check("R9 valid drops", 32'(irq_valid), 32'h0);
    rd(6'd4, d); check("R9 pending cleared", d, 32'h0);
    wr(6'd4, 32'h8);
    expect_req("R10 equal waits", 1'b0, 6'd0);
    wr(6'd4, 32'h4);
    expect_req("R10 preempts", 1'b1, 6'd2);
    accept(6'd2);
    leave();
    expect_req("R11 level restored", 1'b0, 6'd0);
    leave();
    expect_req("R10 tail chain", 1'b1, 6'd3);
    accept(6'd3);
    leave();
    cleanup();
    wr(6'd16, 32'h0040_6000); wr(6'd0, 32'h6); wr(6'd8, 32'h1);
    wr(6'd4, 32'h2);
    expect_req("R10 group first", 1'b1, 6'd1);
    accept(6'd1);
    wr(6'd4, 32'h4);
    expect_req("R10 subprio no preempt", 1'b0, 6'd0);
    leave();
    expect_req("R11 after return", 1'b1, 6'd2);
    accept(6'd2);
    leave();
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enable();
    t_prio();
    t_pend();
    t_arb();
    t_mask();
    t_gate();
    t_nest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule